// File: doc/BRIEF.md
# Subcarrier Synthesizer and Chroma/Composite Mixer

This block builds the colour subcarrier from a 32-bit phase accumulator and uses it to quadrature-modulate a pair of signed colour-difference samples into a chroma sample. It then adds that chroma to a luma sample, which can be held back by a selectable number of sample cycles, to form a composite sample. The composite result is clamped to the unsigned 10-bit range. Samples arrive one per clock at the pixel rate, which comes from a 27 MHz source.

The frequency word is held in an active register. That register reloads only on a line-start strobe or a field-reset pulse, so the subcarrier frequency never changes partway through a line. A field-reset pulse also sets the accumulator phase from the phase-offset input. Sine and cosine come from a single computed parabolic quarter-wave shape, and the cosine is read one quarter turn ahead of the sine.

Top module: `subcarrier_mixer`

## Requirements
- R1: While `rst_n` is low, `chroma` and `cvbs` read 0, the accumulator is 0 and the active frequency word is 0.
- R2: On every clock that has no field reset, the accumulator advances by the active frequency word, modulo 2^32. The table address is accumulator bits [31:22]. With word 0x40000000 the addresses step through 0, 256, 512 and 768.
- R3: A clock with `field_reset` high loads `freq_word` into the active word. It also sets the accumulator to `{phase_ofs, 22'b0}`.
- R4: While neither `line_start` nor `field_reset` is high, changes on `freq_word` have no effect. A clock with `line_start` high loads the new word, and the accumulator uses it from the following clock.
- R5: For a 10-bit address a, let m = a[7:0] when a[8]=0 and m = 256 - a[7:0] when a[8]=1. Then sin(a) = ±floor(m·(512-m)·127/65536), negative when a[9]=1, and cos(a) = sin(a+256 mod 1024). Sample values: sin(0)=0, sin(128)=95, sin(256)=127, sin(768)=-127.
- R6: `chroma` = (u·sin + v·cos) arithmetically shifted right by 6, taken from the accumulator value before the clock that registers it. It appears one clock after `u_in`/`v_in` are sampled.
- R7: A change on `y_in` reaches `cvbs` 2 + d clocks after it is sampled, where d = `luma_dly` for values 0 to 3. Any setting above 3 acts as 3.
- R8: `cvbs` = delayed luma + `chroma`, clamped to 0 when the sum is negative and to 1023 when it is above 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Loads `freq_word` into the active word |
| field_reset | input | 1 | Loads the active word and sets the accumulator phase from `phase_ofs` |
| freq_word | input | 32 | Subcarrier frequency word |
| phase_ofs | input | 10 | Starting phase applied on field reset |
| luma_dly | input | 3 | Extra luma delay in samples, clamped to 3 |
| y_in | input | 10 | Unsigned luma sample |
| u_in | input | 8 | Signed U sample |
| v_in | input | 8 | Signed V sample |
| chroma | output | 10 | Signed chroma sample |
| cvbs | output | 10 | Unsigned saturated composite sample |

## Verification
`chroma` is due one clock after its inputs are sampled, and it uses the accumulator value that was current before that clock. The accumulator takes a new phase one clock after a field-reset pulse, and a new frequency word one clock after a line-start strobe. The bench drives every input on the falling edge and samples after the falling edge that follows the counted rising edges. Each expected value is therefore indexed by the number of rising edges since the stimulus. For the luma delay, the bench steps `y_in` while chroma is zero, counts falling edges until `cvbs` shows the new level, and compares that count with 2 + d.

// File: rtl/subcarrier_mixer.sv
module subcarrier_mixer #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10,
  parameter int UV_W   = 8,
  parameter int OUT_W  = 10,
  parameter int MAX_D  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_start,
  input  logic                    field_reset,
  input  logic [ACC_W-1:0]        freq_word,
  input  logic [ADDR_W-1:0]       phase_ofs,
  input  logic [2:0]              luma_dly,
  input  logic [OUT_W-1:0]        y_in,
  input  logic signed [UV_W-1:0]  u_in,
  input  logic signed [UV_W-1:0]  v_in,
  output logic signed [OUT_W-1:0] chroma,
  output logic [OUT_W-1:0]        cvbs
);
  localparam int QTR   = 1 << (ADDR_W - 2);
  localparam int AMP   = (1 << (UV_W - 1)) - 1;
  localparam int MIX_W = 2 * UV_W + 1;
  localparam int SUM_W = OUT_W + 2;
  localparam int OMAX  = (1 << OUT_W) - 1;

  logic [ACC_W-1:0] acc, freq_act;
  logic [ADDR_W-1:0] addr;
  logic signed [UV_W-1:0] sin_v, cos_v;
  logic signed [MIX_W-1:0] mix;
  logic [OUT_W-1:0] ydl [MAX_D+1];
  logic [1:0] dsel;
  logic [OUT_W-1:0] ysel;
  logic signed [SUM_W-1:0] sum;

  function automatic logic signed [UV_W-1:0] wave(input logic [ADDR_W-1:0] a);
    int m, f;
    m = a[ADDR_W-2] ? QTR - int'(a[ADDR_W-3:0]) : int'(a[ADDR_W-3:0]);
    f = (m * (2 * QTR - m) * AMP) / (QTR * QTR);
    return a[ADDR_W-1] ? UV_W'(-f) : UV_W'(f);
  endfunction

  assign addr  = acc[ACC_W-1 -: ADDR_W];
  assign sin_v = wave(addr);
  assign cos_v = wave(addr + ADDR_W'(QTR));
  assign mix   = MIX_W'(u_in * sin_v) + MIX_W'(v_in * cos_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      freq_act <= '0;
      chroma   <= '0;
    end else begin
      if (field_reset) begin
        acc      <= {phase_ofs, {(ACC_W-ADDR_W){1'b0}}};
        freq_act <= freq_word;
      end else begin
        acc <= acc + freq_act;
        if (line_start) freq_act <= freq_word;
      end
      chroma <= mix[MIX_W-2 -: OUT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ydl[0] <= '0;
    else        ydl[0] <= y_in;
  end

  for (genvar i = 1; i <= MAX_D; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) ydl[i] <= '0;
      else        ydl[i] <= ydl[i-1];
    end
  end

  assign dsel = (luma_dly > 3'(MAX_D)) ? 2'(MAX_D) : luma_dly[1:0];
  assign ysel = ydl[dsel];
  assign sum  = SUM_W'($signed({2'b00, ysel})) + SUM_W'(chroma);

  always_ff @(posedge clk) begin
    if (!rst_n)              cvbs <= '0;
    else if (sum < 0)        cvbs <= '0;
    else if (sum > OMAX)     cvbs <= OUT_W'(OMAX);
    else                     cvbs <= sum[OUT_W-1:0];
  end

  a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !field_reset) |=> freq_act == $past(freq_act));

  a_r3_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
    field_reset |=> (addr == $past(phase_ofs)) && (acc[ACC_W-ADDR_W-1:0] == '0));

  a_r6_zero_colour: assert property (@(posedge clk) disable iff (!rst_n)
    (u_in == '0 && v_in == '0) |=> chroma == '0);

  a_r8_no_dip: assert property (@(posedge clk) disable iff (!rst_n)
    (chroma >= 0) |=> cvbs >= $past(ysel));

  a_r8_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (chroma <= 0) |=> cvbs <= $past(ysel));
endmodule

// File: tb/test_subcarrier_mixer.sv
module test_subcarrier_mixer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, field_reset = 1'b0;
  logic [31:0] freq_word = '0;
  logic [9:0] phase_ofs = '0;
  logic [2:0] luma_dly = '0;
  logic [9:0] y_in = '0;
  logic signed [7:0] u_in = '0, v_in = '0;
  logic signed [9:0] chroma;
  logic [9:0] cvbs;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  subcarrier_mixer i_subcarrier_mixer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_reset(field_reset),
    .freq_word(freq_word), .phase_ofs(phase_ofs), .luma_dly(luma_dly),
    .y_in(y_in), .u_in(u_in), .v_in(v_in), .chroma(chroma), .cvbs(cvbs));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic field_sync(input logic [9:0] ph, input logic [31:0] fw);
    @(negedge clk);
    phase_ofs = ph; freq_word = fw; field_reset = 1'b1;
    @(negedge clk);
    field_reset = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 chroma", int'(chroma), 0);
    check("R1 cvbs", int'(cvbs), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_phase;
    u_in = 8'sd64; v_in = 8'sd0;
    field_sync(10'd256, 32'd0);
    @(negedge clk); check("R3 R5 R6 sin(256)", int'(chroma), 127);
    field_sync(10'd768, 32'd0);
    @(negedge clk); check("R3 R5 R6 sin(768)", int'(chroma), -127);
    field_sync(10'd128, 32'd0);
    @(negedge clk); check("R5 R6 sin(128)", int'(chroma), 95);
    u_in = 8'sd0; v_in = 8'sd64;
    field_sync(10'd0, 32'd0);
    @(negedge clk); @(negedge clk); check("R5 R6 cos(0)", int'(chroma), 127);
    u_in = -8'sd64; v_in = 8'sd0;
    field_sync(10'd256, 32'd0);
    @(negedge clk); check("R6 negative u", int'(chroma), -127);
  endtask

  task automatic t_rotate;
    int exp[4] = '{0, 127, 0, -127};
    u_in = 8'sd64; v_in = 8'sd0;
    field_sync(10'd0, 32'h4000_0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 quarter-turn step", int'(chroma), exp[k]);
    end
  endtask

  task automatic t_line_start;
    u_in = 8'sd64; v_in = 8'sd0;
    field_sync(10'd256, 32'd0);
    freq_word = 32'h4000_0000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 word ignored mid-line", int'(chroma), 127);
    end
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    check("R4 strobe edge", int'(chroma), 127);
    @(negedge clk); check("R4 old word still used", int'(chroma), 127);
    @(negedge clk); check("R4 new word", int'(chroma), 0);
    @(negedge clk); check("R4 new word next", int'(chroma), -127);
  endtask

  task automatic t_delay(input logic [2:0] d, input int exp_lat);
    int lat = 0;
    u_in = 8'sd0; v_in = 8'sd0; luma_dly = d;
    field_sync(10'd0, 32'd0);
    y_in = 10'd100;
    repeat (6) @(negedge clk);
    y_in = 10'd300;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (lat == 0 && cvbs == 10'd300) lat = k;
    end
    check($sformatf("R7 luma latency d=%0d", d), lat, exp_lat);
  endtask

  task automatic t_sat(input logic [9:0] y, input logic signed [7:0] u, input int exp);
    luma_dly = 3'd0; u_in = u; v_in = 8'sd0; y_in = y;
    field_sync(10'd256, 32'd0);
    repeat (4) @(negedge clk);
    check($sformatf("R8 composite y=%0d u=%0d", y, u), int'(cvbs), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_phase();
    t_rotate();
    t_line_start();
    t_delay(3'd0, 2);
    t_delay(3'd1, 3);
    t_delay(3'd2, 4);
    t_delay(3'd3, 5);
    t_delay(3'd6, 5);
    t_sat(10'd500, 8'sd64, 627);
    t_sat(10'd1000, 8'sd64, 1023);
    t_sat(10'd50, -8'sd64, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule